// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit guards a small word-addressed memory and runs indivisible read-modify-write operations on behalf of several requesting agents. Each agent presents an opcode, a word address, a 64-bit operand and, for compare-and-swap, an expected value. It holds its request valid until the unit grants it. A round-robin arbiter picks one agent at a time. The unit then reads the addressed word and writes the result back in the following cycle. It issues no other grant until that write-back is done, so no agent can see or change a word while an operation is in flight.

Every operation answers with the value the word held before the operation and a success flag. The success flag is 0 only for a compare-and-swap whose expected value did not match. Each word is read and written whole, in a single cycle, so no reader can ever see a partly updated word.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads as zero, no response is valid, and no requester is granted while no request is valid.
- R2: Opcode 0 (load) returns the current word with success 1 and leaves the word unchanged.
- R3: Opcode 1 (store) writes the full 64-bit operand in one cycle, returns the prior word with success 1, and a later load returns all 64 bits of the new value.
- R4: Opcode 2 (exchange) writes the operand, returns the prior word and reports success 1.
- R5: Opcode 3 (compare-and-swap) with a prior word equal to the expected value writes the operand, returns the prior word and reports success 1.
- R6: Opcode 3 with a prior word different from the expected value leaves the word unchanged, returns the prior word and reports success 0.
- R7: Opcodes 4 (fetch-add) and 5 (fetch-sub) write old+operand and old-operand, wrapping modulo 2^64, and return the old word with success 1.
- R8: Opcodes 6 (fetch-or), 7 (fetch-and) and 8 (fetch-xor) write the bitwise result of the old word and the operand, and return the old word with success 1.
- R9: When several requesters are valid, the grant goes to the first valid requester at or after the index following the last granted one, wrapping around. At most one requester is granted, and only if it is valid.
- R10: A request is accepted on the clock edge at which its valid and ready are both high. No ready is raised during the two following cycles. The response is valid in the second cycle after acceptance, on exactly the accepted requester's rsp_valid_o bit.
- R11: Opcodes 9 to 15 behave as loads: the word is not written, the old word is returned and success is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Per-requester request valid |
| req_ready_o | output | N_REQ | Per-requester grant; accepted when both valid and ready are high |
| req_op_i | input | N_REQ x 4 | Per-requester opcode |
| req_addr_i | input | N_REQ x ADDR_W | Per-requester word address |
| req_operand_i | input | N_REQ x DATA_W | Per-requester operand or new value |
| req_expect_i | input | N_REQ x DATA_W | Per-requester expected value for compare-and-swap |
| rsp_valid_o | output | N_REQ | One-hot response strobe selecting the requester served |
| rsp_old_o | output | DATA_W | Word value before the operation |
| rsp_success_o | output | 1 | 0 only for a failed compare-and-swap |

## Verification
An accepted request passes through a read cycle and then a write-back cycle, so its response is due exactly two clock edges after the accepting edge. The memory update becomes visible to an operation accepted later. The bench drives inputs and samples outputs on the falling edge. After the accepting edge it checks that the response strobe is low in the read cycle and carries the requester's bit in the following cycle. Value and flag results are taken only at that falling edge. The written word is then checked with a separate load, and the contention test counts the edges between grants to confirm the round-robin order.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    AMO_LOAD  = 4'd0,
    AMO_STORE = 4'd1,
    AMO_SWAP  = 4'd2,
    AMO_CAS   = 4'd3,
    AMO_ADD   = 4'd4,
    AMO_SUB   = 4'd5,
    AMO_OR    = 4'd6,
    AMO_AND   = 4'd7,
    AMO_XOR   = 4'd8
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WB   = 2'd2
  } amo_state_e;
endpackage

// File: rtl/amo_rr_arbiter.sv
module amo_rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] gnt_idx;
  logic          found;

  always_comb begin
    gnt_o   = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (en_i && !found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gnt_idx    = IW'(idx);
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end

  p_gnt_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] operand_i,
  input  logic [W-1:0] expect_i,
  output logic [W-1:0] new_o,
  output logic         we_o,
  output logic         success_o
);
  always_comb begin
    new_o     = old_i;
    we_o      = 1'b1;
    success_o = 1'b1;
    case (op_i)
      AMO_STORE, AMO_SWAP: new_o = operand_i;
      AMO_CAS: begin
        success_o = (old_i == expect_i);
        we_o      = success_o;
        new_o     = operand_i;
      end
      AMO_ADD: new_o = old_i + operand_i;
      AMO_SUB: new_o = old_i - operand_i;
      AMO_OR:  new_o = old_i | operand_i;
      AMO_AND: new_o = old_i & operand_i;
      AMO_XOR: new_o = old_i ^ operand_i;
      default: we_o = 1'b0; // load and undefined codes
    endcase
  end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] words_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) words_q[i] <= '0;
    end else if (we_i) begin
      words_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = words_q[addr_i];
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_valid_i,
  output logic [N_REQ-1:0]              req_ready_o,
  input  logic [N_REQ-1:0][3:0]         req_op_i,
  input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_operand_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_expect_i,
  output logic [N_REQ-1:0]              rsp_valid_o,
  output logic [DATA_W-1:0]             rsp_old_o,
  output logic                          rsp_success_o
);
  amo_state_e              state_q;
  logic [N_REQ-1:0]        owner_q;
  logic [3:0]              op_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       operand_q, expect_q, old_q;

  logic [N_REQ-1:0]        gnt;
  logic                    accept;
  logic [3:0]              sel_op;
  logic [ADDR_W-1:0]       sel_addr;
  logic [DATA_W-1:0]       sel_operand, sel_expect;
  logic [DATA_W-1:0]       mem_rdata, alu_new;
  logic                    alu_we, alu_success, mem_we;

  amo_rr_arbiter #(.N(N_REQ)) i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_IDLE),
    .req_i  (req_valid_i),
    .adv_i  (accept),
    .gnt_o  (gnt)
  );

  assign req_ready_o = gnt;
  assign accept      = |(gnt & req_valid_i);

  always_comb begin
    sel_op      = '0;
    sel_addr    = '0;
    sel_operand = '0;
    sel_expect  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) begin
        sel_op      = req_op_i[i];
        sel_addr    = req_addr_i[i];
        sel_operand = req_operand_i[i];
        sel_expect  = req_expect_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      owner_q   <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      operand_q <= '0;
      expect_q  <= '0;
      old_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_READ;
          owner_q   <= gnt;
          op_q      <= sel_op;
          addr_q    <= sel_addr;
          operand_q <= sel_operand;
          expect_q  <= sel_expect;
        end
        ST_READ: begin
          old_q   <= mem_rdata;
          state_q <= ST_WB;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  amo_alu #(.W(DATA_W)) i_alu (
    .op_i      (op_q),
    .old_i     (old_q),
    .operand_i (operand_q),
    .expect_i  (expect_q),
    .new_o     (alu_new),
    .we_o      (alu_we),
    .success_o (alu_success)
  );

  assign mem_we = (state_q == ST_WB) && alu_we;

  amo_mem #(.W(DATA_W), .DEPTH(DEPTH)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_q),
    .we_i    (mem_we),
    .wdata_i (alu_new),
    .rdata_o (mem_rdata)
  );

  assign rsp_valid_o   = (state_q == ST_WB) ? owner_q : '0;
  assign rsp_old_o     = old_q;
  assign rsp_success_o = (state_q == ST_WB) && alu_success;

  p_one_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_busy_no_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (req_ready_o == '0) ##1 (req_ready_o == '0));
  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 (rsp_valid_o == $past(gnt, 2)));
  p_store_whole_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0 && op_q == AMO_STORE) |=> (mem_rdata == $past(operand_q)));
  p_cas_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0 && op_q == AMO_CAS && !rsp_success_o) |=> (mem_rdata == $past(old_q)));
  p_success_non_cas_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0 && op_q != AMO_CAS) |-> rsp_success_o);
  p_add_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0 && op_q == AMO_ADD) |=> (mem_rdata == $past(old_q) + $past(operand_q)));
  p_no_write_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0 && op_q > 4'd8) |=> (mem_rdata == $past(old_q)));
endmodule

// File: tb/test_atomic_rmw_unit.sv
`timescale 1ns/1ps
module test_atomic_rmw_unit;
  localparam int N = 4;
  localparam int W = 64;
  localparam int D = 16;
  localparam int AW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]          req_valid_i = '0;
  logic [N-1:0]          req_ready_o;
  logic [N-1:0][3:0]     req_op_i = '0;
  logic [N-1:0][AW-1:0]  req_addr_i = '0;
  logic [N-1:0][W-1:0]   req_operand_i = '0;
  logic [N-1:0][W-1:0]   req_expect_i = '0;
  logic [N-1:0]          rsp_valid_o;
  logic [W-1:0]          rsp_old_o;
  logic                  rsp_success_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  atomic_rmw_unit #(.N_REQ(N), .DATA_W(W), .DEPTH(D)) i_atomic_rmw_unit (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_operand_i, .req_expect_i, .rsp_valid_o, .rsp_old_o, .rsp_success_o
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic [W-1:0] r_old;
  logic         r_ok;

  task automatic do_op(input int idx, input logic [3:0] op, input logic [AW-1:0] addr,
                       input logic [W-1:0] opnd, input logic [W-1:0] expv);
    @(negedge clk_i);
    req_valid_i[idx]   = 1'b1;
    req_op_i[idx]      = op;
    req_addr_i[idx]    = addr;
    req_operand_i[idx] = opnd;
    req_expect_i[idx]  = expv;
    #1;
    while (!req_ready_o[idx]) begin @(negedge clk_i); #1; end
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i[idx] = 1'b0;
    chk(rsp_valid_o == '0 && req_ready_o == '0, "R10 busy read cycle", W'(rsp_valid_o), 0);
    @(negedge clk_i);
    chk(rsp_valid_o == N'(1 << idx), "R10 response latency", W'(rsp_valid_o), W'(1 << idx));
    r_old = rsp_old_o;
    r_ok  = rsp_success_o;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    #1;
    chk(rsp_valid_o == '0, "R1 no response", W'(rsp_valid_o), 0);
    chk(req_ready_o == '0, "R1 no grant", W'(req_ready_o), 0);
    for (int a = 0; a < D; a++) begin
      do_op(a % N, 4'd0, AW'(a), '0, '0);
      chk(r_old == '0, "R1 word zero", r_old, '0);
    end
  endtask

  task automatic t_store_load;
    logic [W-1:0] v = 64'hDEAD_BEEF_0123_4567;
    do_op(1, 4'd1, 4'd3, v, '0);
    chk(r_old == '0 && r_ok, "R3 store old", r_old, '0);
    do_op(2, 4'd0, 4'd3, '0, '0);
    chk(r_old == v && r_ok, "R3 whole word", r_old, v);
    do_op(0, 4'd0, 4'd3, '0, '0);
    chk(r_old == v && r_ok, "R2 load unchanged", r_old, v);
  endtask

  task automatic t_exchange;
    logic [W-1:0] x = 64'h0F0F_0000_FFFF_1234;
    do_op(3, 4'd2, 4'd3, x, '0);
    chk(r_old == 64'hDEAD_BEEF_0123_4567 && r_ok, "R4 xchg old", r_old, 64'hDEAD_BEEF_0123_4567);
    do_op(0, 4'd0, 4'd3, '0, '0);
    chk(r_old == x, "R4 xchg new", r_old, x);
  endtask

  task automatic t_cas;
    logic [W-1:0] x = 64'h0F0F_0000_FFFF_1234;
    logic [W-1:0] y = 64'h8000_0000_0000_0001;
    do_op(1, 4'd3, 4'd3, y, x);
    chk(r_old == x, "R5 cas old", r_old, x);
    chk(r_ok == 1'b1, "R5 cas success", W'(r_ok), 1);
    do_op(2, 4'd0, 4'd3, '0, '0);
    chk(r_old == y, "R5 cas wrote", r_old, y);
    do_op(1, 4'd3, 4'd3, 64'h1111, x);
    chk(r_old == y, "R6 cas old", r_old, y);
    chk(r_ok == 1'b0, "R6 cas fail flag", W'(r_ok), 0);
    do_op(2, 4'd0, 4'd3, '0, '0);
    chk(r_old == y, "R6 cas no write", r_old, y);
  endtask

  task automatic t_fetch_arith;
    do_op(0, 4'd1, 4'd5, '1, '0);
    do_op(1, 4'd4, 4'd5, 64'd2, '0);
    chk(r_old == '1 && r_ok, "R7 add old", r_old, '1);
    do_op(2, 4'd0, 4'd5, '0, '0);
    chk(r_old == 64'd1, "R7 add wrap", r_old, 64'd1);
    do_op(3, 4'd5, 4'd5, 64'd3, '0);
    chk(r_old == 64'd1 && r_ok, "R7 sub old", r_old, 64'd1);
    do_op(0, 4'd0, 4'd5, '0, '0);
    chk(r_old == 64'hFFFF_FFFF_FFFF_FFFE, "R7 sub wrap", r_old, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_fetch_logic;
    logic [W-1:0] a = 64'hF0F0_1234_0000_AAAA;
    logic [W-1:0] e;
    do_op(0, 4'd1, 4'd9, a, '0);
    do_op(1, 4'd6, 4'd9, 64'h0F00_0000_FFFF_0005, '0);
    chk(r_old == a && r_ok, "R8 or old", r_old, a);
    e = a | 64'h0F00_0000_FFFF_0005;
    do_op(2, 4'd7, 4'd9, 64'hFF00_FF00_FF00_FF0F, '0);
    chk(r_old == e && r_ok, "R8 and old", r_old, e);
    e = e & 64'hFF00_FF00_FF00_FF0F;
    do_op(3, 4'd8, 4'd9, 64'h1234_5678_9ABC_DEF0, '0);
    chk(r_old == e && r_ok, "R8 xor old", r_old, e);
    e = e ^ 64'h1234_5678_9ABC_DEF0;
    do_op(0, 4'd0, 4'd9, '0, '0);
    chk(r_old == e, "R8 xor result", r_old, e);
  endtask

  task automatic t_bad_opcode;
    do_op(2, 4'd12, 4'd3, 64'hABCD, 64'h8000_0000_0000_0001);
    chk(r_old == 64'h8000_0000_0000_0001 && r_ok, "R11 undefined op old", r_old, 64'h8000_0000_0000_0001);
    do_op(1, 4'd15, 4'd3, 64'h1, '0);
    do_op(0, 4'd0, 4'd3, '0, '0);
    chk(r_old == 64'h8000_0000_0000_0001, "R11 no write", r_old, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_round_robin;
    do_op(3, 4'd1, 4'd7, '0, '0); // pointer now at requester 0
    @(negedge clk_i);
    for (int i = 0; i < N; i++) begin
      req_valid_i[i] = 1'b1; req_op_i[i] = 4'd4; req_addr_i[i] = 4'd7;
      req_operand_i[i] = 64'd1; req_expect_i[i] = '0;
    end
    for (int g = 0; g < N; g++) begin
      int waits = 0;
      #1;
      while (req_ready_o == '0 && waits < 10) begin @(negedge clk_i); #1; waits++; end
      chk(req_ready_o == N'(1 << g), "R9 round-robin grant", W'(req_ready_o), W'(1 << g));
      @(posedge clk_i);
      @(negedge clk_i);
      req_valid_i[g] = 1'b0;
      @(negedge clk_i);
      chk(rsp_valid_o == N'(1 << g), "R10 contended response", W'(rsp_valid_o), W'(1 << g));
      chk(rsp_old_o == W'(g) && rsp_success_o, "R9 serialized add", rsp_old_o, W'(g));
      @(negedge clk_i);
    end
    do_op(1, 4'd0, 4'd7, '0, '0);
    chk(r_old == 64'd4, "R10 no lost update", r_old, 64'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_store_load();
    t_exchange();
    t_cas();
    t_fetch_arith();
    t_fetch_logic();
    t_bad_opcode();
    t_round_robin();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule